// File: doc/BRIEF.md
# Byte and Line Subsampling Filter

This block sits in a camera pixel path, after the stage that qualifies synchronisation and before the stage that packs bytes into words. Each cycle it may receive one 8-bit data byte with a valid strobe. That byte can also carry a line-start marker and a frame-start marker. The block passes on only some of these bytes. Its output is a registered byte stream that keeps its own line-start and frame-start markers.

Two settings decide what is kept. Within a line, the block can keep every byte, one byte in two, one byte in four, or one pair of bytes in four. A phase bit picks the first or the second slot of each group. Within a frame, the block can keep every line or one line in two, again with a phase bit. The byte position counts from zero at every line start. The line index counts from zero at every frame start. Configuration is expected to stay constant during a frame.

Top module: `pix_subsample`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid`, `out_sol` and `out_sof` are 0.
- R2: A kept byte appears on `out_data` with `out_valid` high exactly one clock after it was presented, with its value unchanged. With byte mode 0 and line mode 0, every valid byte is kept.
- R3: Byte mode 1 keeps a byte at line position p (0-based) when p mod 2 equals `cfg_byte_odd`.
- R4: Byte mode 2 keeps a byte at position p when p mod 4 equals `cfg_byte_odd` (0 or 1).
- R5: Byte mode 3 keeps bytes in pairs. It keeps position p when (p mod 4) div 2 equals `cfg_byte_odd`.
- R6: The byte position returns to 0 at every accepted byte that carries `in_sol` or `in_sof`, whatever the previous line length was.
- R7: Line mode 0 keeps all lines. Line mode 1 keeps line l (0-based, line 0 being the one that begins with `in_sof`) when l mod 2 equals `cfg_line_odd`. Every `in_sol` without `in_sof` advances l by one.
- R8: A dropped line produces no output bytes and no `out_sol`, whatever the byte settings are.
- R9: `out_sol` is high with the first kept byte of each kept line. `out_sof` is high with the first kept byte after a frame start. Neither marker is ever high without `out_valid`.
- R10: A cycle with `in_valid` low produces no output byte. Any `in_sol`, `in_sof` or `in_data` in that cycle is ignored and does not move either phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte_mode | input | 2 | 0 all, 1 one-of-two, 2 one-of-four, 3 pair-of-four |
| cfg_byte_odd | input | 1 | Byte slot phase select |
| cfg_line_mode | input | 1 | 0 all lines, 1 one-of-two |
| cfg_line_odd | input | 1 | Line phase select |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | DATA_W | Input byte |
| in_sol | input | 1 | Input byte starts a line |
| in_sof | input | 1 | Input byte starts a frame (and a line) |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | DATA_W | Output byte |
| out_sol | output | 1 | First kept byte of a kept line |
| out_sof | output | 1 | First kept byte of a frame |

## Verification
The bench sweeps all 32 combinations of byte mode, byte phase, line mode and line phase. For each combination it sends two frames of three lines each, with line lengths of 5, 6 and 7 bytes. These lengths are not multiples of four, so a byte position that failed to restart at a line start would put the wrong slots on the next line. Idle cycles carrying stray markers and junk data are mixed in, which shows whether invalid cycles really have no effect. The line phases of the two frames show whether the line index restarts at each frame start, and dropped leading lines show whether the frame-start marker is held until the first kept byte.

// File: rtl/pix_subsample_pkg.sv
package pix_subsample_pkg;

  typedef enum logic [1:0] {
    BSEL_ALL  = 2'd0,
    BSEL_HALF = 2'd1,
    BSEL_QUAR = 2'd2,
    BSEL_PAIR = 2'd3
  } bsel_mode_e;

  localparam int unsigned GROUP_W = 2;

  function automatic logic byte_pick(bsel_mode_e mode, logic odd,
                                     logic [GROUP_W-1:0] pos);
    logic r;
    unique case (mode)
      BSEL_ALL:  r = 1'b1;
      BSEL_HALF: r = (pos[0] == odd);
      BSEL_QUAR: r = (pos == {1'b0, odd});
      BSEL_PAIR: r = (pos[1] == odd);
      default:   r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pix_byte_phase.sv
module pix_byte_phase
  import pix_subsample_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc,
  input  logic       start,
  input  bsel_mode_e mode,
  input  logic       odd,
  output logic       keep
);
  logic [GROUP_W-1:0] pos_q;
  logic [GROUP_W-1:0] pos_cur;

  assign pos_cur = start ? '0 : pos_q;
  assign keep    = byte_pick(mode, odd, pos_cur);

  always_ff @(posedge clk) begin
    if (rst)      pos_q <= '0;
    else if (acc) pos_q <= pos_cur + 1'b1;
  end

  assert_pos_restart_R6: assert property (@(posedge clk) disable iff (rst)
    acc && start |=> pos_q == GROUP_W'(1));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(pos_q));
endmodule

// File: rtl/pix_line_phase.sv
module pix_line_phase (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic sol,
  input  logic sof,
  input  logic mode,
  input  logic odd,
  output logic keep
);
  logic ph_q;
  logic ph_cur;

  always_comb begin
    if (sof)      ph_cur = 1'b0;
    else if (sol) ph_cur = ~ph_q;
    else          ph_cur = ph_q;
  end

  assign keep = !mode || (ph_cur == odd);

  always_ff @(posedge clk) begin
    if (rst)      ph_q <= 1'b1;
    else if (acc) ph_q <= ph_cur;
  end

  assert_line_restart_R7: assert property (@(posedge clk) disable iff (rst)
    acc && sof |=> !ph_q);
  assert_line_step_R7: assert property (@(posedge clk) disable iff (rst)
    acc && sol && !sof |=> ph_q != $past(ph_q));
endmodule

// File: rtl/pix_mark_track.sv
module pix_mark_track (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic fire,
  input  logic sol,
  input  logic sof,
  input  logic line_keep,
  output logic sof_now,
  output logic sol_now
);
  logic sof_pend_q;
  logic sol_pend_q;

  assign sof_now = sof || sof_pend_q;
  assign sol_now = sol ? line_keep : sol_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sof_pend_q <= 1'b0;
      sol_pend_q <= 1'b0;
    end else if (acc) begin
      sof_pend_q <= sof_now && !fire;
      sol_pend_q <= sol_now && !fire;
    end
  end

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (rst)
    fire |=> !sof_pend_q && !sol_pend_q);
endmodule

// File: rtl/pix_subsample.sv
module pix_subsample
  import pix_subsample_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_byte_mode,
  input  logic              cfg_byte_odd,
  input  logic              cfg_line_mode,
  input  logic              cfg_line_odd,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sol,
  input  logic              in_sof,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sol,
  output logic              out_sof
);
  localparam bit BYTE_WIDE = (DATA_W == 8);

  bsel_mode_e bmode;
  logic       line_start;
  logic       byte_keep;
  logic       line_keep;
  logic       fire;
  logic       sof_now;
  logic       sol_now;

  generate
    if (BYTE_WIDE) begin : g_bsel
      assign bmode = bsel_mode_e'(cfg_byte_mode);
    end else begin : g_nobsel
      assign bmode = BSEL_ALL;
    end
  endgenerate

  assign line_start = in_sol || in_sof;
  assign fire       = in_valid && line_keep && byte_keep;

  pix_byte_phase u_byte (
    .clk   (clk),
    .rst   (rst),
    .acc   (in_valid),
    .start (line_start),
    .mode  (bmode),
    .odd   (cfg_byte_odd),
    .keep  (byte_keep)
  );

  pix_line_phase u_line (
    .clk  (clk),
    .rst  (rst),
    .acc  (in_valid),
    .sol  (line_start),
    .sof  (in_sof),
    .mode (cfg_line_mode),
    .odd  (cfg_line_odd),
    .keep (line_keep)
  );

  pix_mark_track u_mark (
    .clk       (clk),
    .rst       (rst),
    .acc       (in_valid),
    .fire      (fire),
    .sol       (line_start),
    .sof       (in_sof),
    .line_keep (line_keep),
    .sof_now   (sof_now),
    .sol_now   (sol_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      out_sol   <= fire && sol_now;
      out_sof   <= fire && sof_now;
      if (fire) out_data <= in_data;
    end
  end

  assert_idle_no_out_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_pass_all_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && cfg_byte_mode == 2'd0 && !cfg_line_mode
    |=> out_valid && out_data == $past(in_data));
  assert_marker_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_sol) |-> out_valid);
  assert_sof_pass_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sof && cfg_byte_mode == 2'd0 && !cfg_line_mode |=> out_sof);
  assert_drop_line_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && !line_keep |=> !out_valid && !out_sol);
endmodule

// File: tb/sim_pix_subsample.sv
module sim_pix_subsample;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_byte_mode = '0;
  logic       cfg_byte_odd = 1'b0;
  logic       cfg_line_mode = 1'b0;
  logic       cfg_line_odd = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_sol = 1'b0;
  logic       in_sof = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sol;
  logic       out_sof;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int  m_pos, m_line;
  bit  m_sofp, m_solp;
  bit  e_v, e_sof, e_sol;
  logic [7:0] e_d;
  string e_tag;
  int  idle_cnt;

  always #5 clk = ~clk;

  pix_subsample #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst),
    .cfg_byte_mode(cfg_byte_mode), .cfg_byte_odd(cfg_byte_odd),
    .cfg_line_mode(cfg_line_mode), .cfg_line_odd(cfg_line_odd),
    .in_valid(in_valid), .in_data(in_data), .in_sol(in_sol), .in_sof(in_sof),
    .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d odd %0d lmode %0d lodd %0d)",
               tag, act, exp, cfg_byte_mode, cfg_byte_odd, cfg_line_mode, cfg_line_odd);
    end
  endtask

  task automatic compare();
    chk(out_valid == e_v, {e_tag, " valid"}, out_valid, e_v);
    chk(out_sof == e_sof, "R9 out_sof", out_sof, e_sof);
    chk(out_sol == e_sol, "R9 R8 out_sol", out_sol, e_sol);
    if (e_v) chk(out_data == e_d, "R2 data", out_data, e_d);
  endtask

  function automatic bit pick(int mode, bit odd, int pos);
    int p = pos % 4;
    case (mode)
      0: return 1'b1;
      1: return (p % 2) == odd;    // R3
      2: return p == int'(odd);    // R4
      default: return (p / 2) == odd; // R5
    endcase
  endfunction

  // present one input cycle; first check the result of the previous cycle
  task automatic step(input bit v, input bit sof, input bit sol, input logic [7:0] d);
    bit lk, bk, keep, sofn, soln;
    @(negedge clk);
    compare();
    in_valid = v; in_sof = sof; in_sol = sol; in_data = d;
    e_v = 0; e_sof = 0; e_sol = 0; e_tag = "R10 idle";
    if (v) begin
      if (sof) m_line = 0;
      else if (sol) m_line++;
      if (sof || sol) m_pos = 0;     // R6
      lk   = !cfg_line_mode || ((m_line % 2) == cfg_line_odd);
      bk   = pick(cfg_byte_mode, cfg_byte_odd, m_pos);
      keep = lk && bk;
      sofn = sof || m_sofp;
      soln = (sof || sol) ? lk : m_solp;
      if (keep) begin
        e_v = 1; e_sof = sofn; e_sol = soln; e_d = d;
        m_sofp = 0; m_solp = 0;
      end else begin
        m_sofp = sofn; m_solp = soln;
      end
      if (!lk) e_tag = "R8 R7 line";
      else case (cfg_byte_mode)
        0: e_tag = "R2 all";
        1: e_tag = "R3 R6 half";
        2: e_tag = "R4 R6 quarter";
        default: e_tag = "R5 R6 pair";
      endcase
      m_pos++;
    end
  endtask

  task automatic maybe_idle();
    idle_cnt++;
    if (idle_cnt % 3 == 2) step(1'b0, 1'b1, 1'b1, 8'hEE); // stray markers: R10
  endtask

  task automatic run_cfg(input int bm, input bit bo, input bit lm, input bit lo);
    @(negedge clk);
    rst = 1'b1; in_valid = 0; in_sol = 0; in_sof = 0;
    cfg_byte_mode = 2'(bm); cfg_byte_odd = bo; cfg_line_mode = lm; cfg_line_odd = lo;
    @(negedge clk);
    chk(!out_valid && !out_sol && !out_sof, "R1 reset", {out_valid, out_sol, out_sof}, 0);
    rst = 1'b0;
    m_pos = 0; m_line = -1; m_sofp = 0; m_solp = 0;
    e_v = 0; e_sof = 0; e_sol = 0; e_tag = "R1 after reset"; e_d = '0;
    for (int f = 0; f < 2; f++) begin
      for (int l = 0; l < 3; l++) begin
        for (int b = 0; b < 5 + l; b++) begin
          step(1'b1, (l == 0 && b == 0), (b == 0), 8'((f << 6) | (l << 4) | b));
          maybe_idle();
        end
      end
    end
    step(1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    idle_cnt = 0;
    for (int bm = 0; bm < 4; bm++)
      for (int bo = 0; bo < 2; bo++)
        for (int lm = 0; lm < 2; lm++)
          for (int lo = 0; lo < 2; lo++)
            run_cfg(bm, bit'(bo), bit'(lm), bit'(lo));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule